// File: doc/BRIEF.md
# DDR SDRAM Command Timing Guard

This block watches the command stream that a memory controller is about to send to a four-bank DDR SDRAM. For every proposed command it reports, in the same cycle, whether the command obeys the device's state and timing rules. It also keeps a per-bank open/closed view and flags rows that have been held open too long. The controller presents a command with a bank and an auto-precharge bit. It may send the command only when the block reports it legal. A command the block calls illegal is treated as not sent and leaves all tracked state untouched.

Every delay is a parameter counted in clock cycles. The defaults match a 250 MHz speed grade. A free-running interval timer raises a refresh request every `REF_INT` cycles, which is 7.8 us at 250 MHz. An accepted refresh drops the request and restarts the interval.

Top module: `dram_cmd_timing_guard`

## Requirements
- R1: After reset all banks read as closed, `refresh_due` and `row_overdue` are low, all timers are expired, and with `cmd_valid` low both `cmd_ok` and `cmd_bad` are low.
- R2: An activate (`cmd_op`=0) is legal only if the bank is closed, at least 15 cycles have passed since that bank's previous activate, at least 3 cycles have passed since any activate, and at least 5 cycles have passed since the bank was precharged.
- R3: A read (`cmd_op`=1) is legal only to an open bank, at least 5 cycles after its activate, and at least 3 cycles after the most recent accepted write to any bank, so a write burst is never cut by a read.
- R4: A write (`cmd_op`=2) is legal only to an open bank, at least 3 cycles after its activate.
- R5: A precharge (`cmd_op`=3) of an open bank needs at least 10 cycles since its activate and at least 4 cycles since its last write (two data cycles plus 2 of recovery). A precharge of a closed bank is legal and has no effect. Precharge-all (`cmd_op`=4) is legal only when every open bank meets both limits.
- R6: A read or write with `cmd_ap`=1 (address bit A8) closes the bank. A later activate then needs 7 cycles after a read or 10 cycles after a write, in addition to the R2 limits.
- R7: A refresh (`cmd_op`=5) is legal only when every bank is closed and past its R5/R6 reopen delay. After an accepted refresh every command is illegal for the next 16 cycles, and `refresh_due` is low in the following cycle.
- R8: A mode register write (`cmd_op`=6) is legal under the same all-idle condition as R7. After it, every command is illegal for the next cycle.
- R9: `cmd_bad` equals `cmd_valid` and not `cmd_ok`. `cmd_op`=7 is always illegal. An illegal command changes no state.
- R10: `refresh_due` goes high after `REF_INT` clock edges since reset or since the last accepted refresh.
- R11: `row_overdue[b]` goes high once bank b has been open for more than `T_RAS_MAX` cycles.
- R12: `bank_open[b]` is high from the cycle after an accepted activate of bank b until the cycle after it is closed by a precharge, a precharge-all or an auto-precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is proposed this cycle |
| cmd_op | input | 3 | Command code (see R2 to R9) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge request on a read or write |
| bank_open | output | 4 | Per-bank open (row active) flag |
| cmd_ok | output | 1 | Proposed command is legal and is taken |
| cmd_bad | output | 1 | Proposed command breaks a rule |
| refresh_due | output | 1 | A refresh should be issued |
| row_overdue | output | 4 | Per-bank row held open too long |

## Verification
The hardest case to reach from the ports is a command that sits exactly on a boundary where several delays end in the same cycle. Examples are an activate whose same-bank cycle limit, reopen delay and cross-bank spacing all expire together, or a read that the write-burst guard alone holds off. Directed sequences place commands one cycle before and exactly at each limit in turn. A long stretch of weighted random commands with idle gaps then builds overlapping bank histories. A timestamp model in the bench judges every one of those random commands.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
// Shared types for the command timing guard.
// Assumes a 3-bit command code; code 7 is reserved and always illegal.
package dtg_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_REF  = 3'd5,
        OP_MRS  = 3'd6,
        OP_RSVD = 3'd7
    } dtg_op_e;

    // Larger of two integers, used to size counters.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dtg_down_ctr.sv
`timescale 1ns/1ps
// Loadable down-counter that stops at zero.
// A limit of T cycles is enforced by loading T-1 with the command;
// a later command is allowed once zero is reported.
module dtg_down_ctr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load on command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= value;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/dtg_bank_track.sv
`timescale 1ns/1ps
// State and timers for one bank: open flag, activate-to-column,
// minimum open time, same-bank activate spacing, write recovery,
// reopen delay after a close, and the open-age watchdog.
// Assumes the do_* strobes are only raised for accepted commands
// and do_close only while the bank is open.
module dtg_bank_track #(
    parameter int CW        = 6,
    parameter int T_RCD_RD  = 5,
    parameter int T_RCD_WR  = 3,
    parameter int T_RAS     = 10,
    parameter int T_RC      = 15,
    parameter int T_RP      = 5,
    parameter int WR2PRE    = 4,
    parameter int RDAP2ACT  = 7,
    parameter int WRAP2ACT  = 10,
    parameter int T_RAS_MAX = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_rd,
    input  logic do_wr,
    input  logic do_close,
    input  logic auto_pre,
    output logic is_open,
    output logic act_ready,
    output logic rd_ready,
    output logic wr_ready,
    output logic pre_ready,
    output logic idle_ready,
    output logic overdue
);

    localparam int AW = $clog2(T_RAS_MAX + 2);
    localparam logic [AW-1:0] AGE_TOP  = AW'(T_RAS_MAX + 1);
    localparam logic [CW-1:0] L_RCDRD  = CW'(T_RCD_RD - 1);
    localparam logic [CW-1:0] L_RCDWR  = CW'(T_RCD_WR - 1);
    localparam logic [CW-1:0] L_RAS    = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RC     = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RP     = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_WRREC  = CW'(WR2PRE - 1);
    localparam logic [CW-1:0] L_RDAP   = CW'(RDAP2ACT - 1);
    localparam logic [CW-1:0] L_WRAP   = CW'(WRAP2ACT - 1);

    logic          open_q;
    logic [AW-1:0] age_q;
    logic          col_shut;
    logic          wait_load;
    logic [CW-1:0] wait_val;
    logic z_rcdrd, z_rcdwr, z_ras, z_rc, z_wrrec, z_wait;

    assign col_shut  = (do_rd | do_wr) & auto_pre;
    assign wait_load = do_close | col_shut;

    // Reopen delay depends on what closed the bank.
    always_comb begin
        if (do_close)   wait_val = L_RP;
        else if (do_wr) wait_val = L_WRAP;
        else            wait_val = L_RDAP;
    end

    // Open flag follows activate and every kind of close.
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else if (do_act)
            open_q <= 1'b1;
        else if (do_close | col_shut)
            open_q <= 1'b0;
    end

    // Age of the open row, saturating just past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= '0;
        else if (do_act)
            age_q <= '0;
        else if (open_q && age_q != AGE_TOP)
            age_q <= age_q + 1'b1;
    end

    dtg_down_ctr #(.W(CW)) u_rcdrd (.clk(clk), .rst_n(rst_n), .load(do_act),    .value(L_RCDRD), .zero(z_rcdrd));
    dtg_down_ctr #(.W(CW)) u_rcdwr (.clk(clk), .rst_n(rst_n), .load(do_act),    .value(L_RCDWR), .zero(z_rcdwr));
    dtg_down_ctr #(.W(CW)) u_ras   (.clk(clk), .rst_n(rst_n), .load(do_act),    .value(L_RAS),   .zero(z_ras));
    dtg_down_ctr #(.W(CW)) u_rc    (.clk(clk), .rst_n(rst_n), .load(do_act),    .value(L_RC),    .zero(z_rc));
    dtg_down_ctr #(.W(CW)) u_wrrec (.clk(clk), .rst_n(rst_n), .load(do_wr),     .value(L_WRREC), .zero(z_wrrec));
    dtg_down_ctr #(.W(CW)) u_wait  (.clk(clk), .rst_n(rst_n), .load(wait_load), .value(wait_val), .zero(z_wait));

    assign is_open    = open_q;
    assign act_ready  = !open_q && z_wait && z_rc;
    assign rd_ready   = open_q && z_rcdrd;
    assign wr_ready   = open_q && z_rcdwr;
    assign pre_ready  = !open_q || (z_ras && z_wrrec);
    assign idle_ready = !open_q && z_wait;
    assign overdue    = open_q && (age_q > AW'(T_RAS_MAX));

endmodule

// File: rtl/dtg_refresh_timer.sv
`timescale 1ns/1ps
// Refresh interval timer: raises due after REF_INT cycles and holds it
// until an accepted refresh, which also restarts the interval.
module dtg_refresh_timer #(
    parameter int REF_INT = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_done,
    output logic due
);

    localparam int RW = $clog2(REF_INT + 1);
    localparam logic [RW-1:0] LAST = RW'(REF_INT - 1);

    logic [RW-1:0] cnt_q;
    logic          due_q;

    // Interval count and request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due_q <= 1'b0;
        end else if (refresh_done) begin
            cnt_q <= '0;
            due_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            due_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign due = due_q;

endmodule

// File: rtl/dram_cmd_timing_guard.sv
`timescale 1ns/1ps
// Judges each proposed SDRAM command against bank state and timing.
// Legal commands update the state; illegal ones are dropped.
// Assumes one command per cycle and that every delay parameter is >= 1.
module dram_cmd_timing_guard #(
    parameter int NBANK     = 4,
    parameter int BURST     = 4,
    parameter int T_RCD_RD  = 5,
    parameter int T_RCD_WR  = 3,
    parameter int T_RAS     = 10,
    parameter int T_RC      = 15,
    parameter int T_RP      = 5,
    parameter int T_RRD     = 3,
    parameter int T_CCD     = 1,
    parameter int T_WR      = 2,
    parameter int T_DAL     = 8,
    parameter int T_RFC     = 17,
    parameter int T_MRD     = 2,
    parameter int REF_INT   = 1950,
    parameter int T_RAS_MAX = 100000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [$clog2(NBANK)-1:0] cmd_bank,
    input  logic                     cmd_ap,
    output logic [NBANK-1:0]         bank_open,
    output logic                     cmd_ok,
    output logic                     cmd_bad,
    output logic                     refresh_due,
    output logic [NBANK-1:0]         row_overdue
);
    import dtg_pkg::*;

    localparam int BA_W     = $clog2(NBANK);
    localparam int BEAT_CYC = BURST / 2;
    localparam int WR2PRE   = BEAT_CYC + T_WR;
    localparam int WRAP2ACT = BEAT_CYC + T_DAL;
    localparam int RDAP2ACT = BEAT_CYC + T_RP;
    localparam int WR2RD    = BEAT_CYC + 1;
    localparam int MAXT     = max2(max2(max2(T_RC, T_RFC), max2(WRAP2ACT, RDAP2ACT)),
                                   max2(max2(T_RAS, T_RCD_RD), max2(WR2PRE, T_MRD)));
    localparam int CW       = $clog2(MAXT + 1);

    dtg_op_e          op;
    logic             legal;
    logic             acc;
    logic [NBANK-1:0] act_rdy, rd_rdy, wr_rdy, pre_rdy, idle_rdy;
    logic z_rrd, z_ccd, z_wrrd, z_gbl;
    logic [CW-1:0] gbl_val;

    assign op  = dtg_op_e'(cmd_op);
    assign acc = cmd_valid && legal;

    // One tracker per bank.
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic hit;
        assign hit = (cmd_bank == BA_W'(i));
        dtg_bank_track #(
            .CW(CW), .T_RCD_RD(T_RCD_RD), .T_RCD_WR(T_RCD_WR), .T_RAS(T_RAS),
            .T_RC(T_RC), .T_RP(T_RP), .WR2PRE(WR2PRE), .RDAP2ACT(RDAP2ACT),
            .WRAP2ACT(WRAP2ACT), .T_RAS_MAX(T_RAS_MAX)
        ) u_track (
            .clk       (clk),
            .rst_n     (rst_n),
            .do_act    (acc && op == OP_ACT && hit),
            .do_rd     (acc && op == OP_RD && hit),
            .do_wr     (acc && op == OP_WR && hit),
            .do_close  (acc && bank_open[i] && ((op == OP_PRE && hit) || op == OP_PREA)),
            .auto_pre  (cmd_ap),
            .is_open   (bank_open[i]),
            .act_ready (act_rdy[i]),
            .rd_ready  (rd_rdy[i]),
            .wr_ready  (wr_rdy[i]),
            .pre_ready (pre_rdy[i]),
            .idle_ready(idle_rdy[i]),
            .overdue   (row_overdue[i])
        );
    end

    // Refresh and mode writes each block all commands for their own span.
    assign gbl_val = (op == OP_REF) ? CW'(T_RFC - 1) : CW'(T_MRD - 1);

    dtg_down_ctr #(.W(CW)) u_rrd  (.clk(clk), .rst_n(rst_n), .load(acc && op == OP_ACT),
                                   .value(CW'(T_RRD - 1)), .zero(z_rrd));
    dtg_down_ctr #(.W(CW)) u_ccd  (.clk(clk), .rst_n(rst_n), .load(acc && (op == OP_RD || op == OP_WR)),
                                   .value(CW'(T_CCD - 1)), .zero(z_ccd));
    dtg_down_ctr #(.W(CW)) u_wrrd (.clk(clk), .rst_n(rst_n), .load(acc && op == OP_WR),
                                   .value(CW'(WR2RD - 1)), .zero(z_wrrd));
    dtg_down_ctr #(.W(CW)) u_gbl  (.clk(clk), .rst_n(rst_n), .load(acc && (op == OP_REF || op == OP_MRS)),
                                   .value(gbl_val), .zero(z_gbl));

    dtg_refresh_timer #(.REF_INT(REF_INT)) u_ref (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_done(acc && op == OP_REF),
        .due         (refresh_due)
    );

    // Rule selection for the proposed command.
    always_comb begin
        legal = 1'b0;
        if (z_gbl) begin
            case (op)
                OP_ACT:  legal = act_rdy[cmd_bank] && z_rrd;
                OP_RD:   legal = rd_rdy[cmd_bank] && z_wrrd && z_ccd;
                OP_WR:   legal = wr_rdy[cmd_bank] && z_ccd;
                OP_PRE:  legal = pre_rdy[cmd_bank];
                OP_PREA: legal = &pre_rdy;
                OP_REF:  legal = &idle_rdy;
                OP_MRS:  legal = &idle_rdy;
                default: legal = 1'b0;
            endcase
        end
    end

    assign cmd_ok  = acc;
    assign cmd_bad = cmd_valid && !legal;

endmodule

// File: rtl/dtg_checker.sv
`timescale 1ns/1ps
// Property checker for the command timing guard, bound to its top.
module dtg_checker #(
    parameter int NBANK = 4,
    parameter int T_RRD = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [2:0]               cmd_op,
    input logic [$clog2(NBANK)-1:0] cmd_bank,
    input logic [NBANK-1:0]         bank_open,
    input logic                     cmd_ok,
    input logic                     cmd_bad,
    input logic                     refresh_due,
    input logic [NBANK-1:0]         row_overdue
);

    // R9
    ok_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && cmd_bad));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (!cmd_ok && !cmd_bad));

    // R12
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd0) |=> bank_open[$past(cmd_bank)]);

    // R5
    pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd3) |=> !bank_open[$past(cmd_bank)]);

    // R8
    mrs_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd6) |-> (bank_open == '0));

    // R7
    ref_clears_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd5) |=> !refresh_due);

    // R3
    rd_after_wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd1) |-> !$past(rst_n && cmd_ok && cmd_op == 3'd2));

    // R2
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (T_RRD >= 2 && cmd_ok && cmd_op == 3'd0) |-> !$past(rst_n && cmd_ok && cmd_op == 3'd0));

    // R11
    overdue_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_overdue & ~bank_open) == '0);

endmodule

bind dram_cmd_timing_guard dtg_checker #(.NBANK(NBANK), .T_RRD(T_RRD)) u_dtg_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .bank_open  (bank_open),
    .cmd_ok     (cmd_ok),
    .cmd_bad    (cmd_bad),
    .refresh_due(refresh_due),
    .row_overdue(row_overdue)
);

// File: tb/test_dram_cmd_timing_guard.sv
`timescale 1ns/1ps
module test_dram_cmd_timing_guard;

    localparam int REF_N  = 1950;
    localparam int AGE_N  = 120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_ap = 1'b0;
    logic [3:0] bank_open;
    logic       cmd_ok, cmd_bad, refresh_due;
    logic [3:0] row_overdue;

    int n_chk = 0;
    int n_bad = 0;
    int ecnt  = 0;
    int last_c = 0;
    bit last_got = 1'b0;

    // Timestamp model: earliest legal cycle for each rule.
    bit mopen [4];
    int act_at[4], rc_at[4], rd_at[4], wr_at[4], pre_at[4];
    int rrd_at = 0, rdw_at = 0, gbl_at = 0;

    dram_cmd_timing_guard #(.T_RAS_MAX(AGE_N), .REF_INT(REF_N)) i_dram_cmd_timing_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .bank_open(bank_open),
        .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .refresh_due(refresh_due),
        .row_overdue(row_overdue)
    );

    always #10 clk = ~clk;

    // Clock edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d at edge %0d", tag, got, exp, ecnt);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [3:0] mvec();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = mopen[i];
        return v;
    endfunction

    function automatic bit mlegal(input int op, input int b, input int c);
        bit ok;
        if (c < gbl_at) return 1'b0;
        case (op)
            0: return !mopen[b] && c >= act_at[b] && c >= rc_at[b] && c >= rrd_at;
            1: return mopen[b] && c >= rd_at[b] && c >= rdw_at;
            2: return mopen[b] && c >= wr_at[b];
            3: return !mopen[b] || c >= pre_at[b];
            4: begin
                ok = 1'b1;
                for (int i = 0; i < 4; i++) if (mopen[i] && c < pre_at[i]) ok = 1'b0;
                return ok;
            end
            5, 6: begin
                ok = 1'b1;
                for (int i = 0; i < 4; i++) if (mopen[i] || c < act_at[i]) ok = 1'b0;
                return ok;
            end
            default: return 1'b0;
        endcase
    endfunction

    task automatic mapply(input int op, input int b, input bit ap, input int c);
        case (op)
            0: begin
                mopen[b] = 1'b1; rd_at[b] = c + 5; wr_at[b] = c + 3;
                pre_at[b] = c + 10; rc_at[b] = c + 15; rrd_at = c + 3;
            end
            1: if (ap) begin mopen[b] = 1'b0; act_at[b] = c + 7; end
            2: begin
                pre_at[b] = imax(pre_at[b], c + 4); rdw_at = c + 3;
                if (ap) begin mopen[b] = 1'b0; act_at[b] = c + 10; end
            end
            3: if (mopen[b]) begin mopen[b] = 1'b0; act_at[b] = c + 5; end
            4: for (int i = 0; i < 4; i++)
                   if (mopen[i]) begin mopen[i] = 1'b0; act_at[i] = c + 5; end
            5: gbl_at = c + 17;
            6: gbl_at = c + 2;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input int op, input bit ap);
        case (op)
            0: return "R2";
            1: return ap ? "R6" : "R3";
            2: return ap ? "R6" : "R4";
            3, 4: return "R5";
            5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    // One command cycle, judged against the model.
    task automatic step(input bit v, input int op, input int b, input bit ap);
        bit exp;
        int c;
        @(negedge clk);
        cmd_valid = v; cmd_op = op[2:0]; cmd_bank = b[1:0]; cmd_ap = ap;
        #1;
        c = ecnt;
        last_c = c;
        check("R12", bank_open, mvec());
        exp = v && mlegal(op, b, c);
        last_got = cmd_ok;
        if (v) check(tag_of(op, ap), cmd_ok, exp);
        check("R9", cmd_bad, v && !exp);
        @(posedge clk);
        if (exp) mapply(op, b, ap, c);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic dstep(input int op, input int b, input bit ap, input bit want, input string tag);
        step(1'b1, op, b, ap);
        check(tag, last_got, want);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0);
    endtask

    task automatic wait_edges(input int tgt);
        while (ecnt < tgt) @(negedge clk);
        #1;
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r, op, b;
        bit ap;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin
            mopen[i] = 1'b0; act_at[i] = 0; rc_at[i] = 0;
            rd_at[i] = 0; wr_at[i] = 0; pre_at[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", bank_open, 0);
        check("R1", refresh_due, 0);
        check("R1", row_overdue, 0);
        check("R1", cmd_ok, 0);
        check("R1", cmd_bad, 0);

        // R10 refresh interval from reset
        wait_edges(REF_N - 1);
        check("R10", refresh_due, 0);
        wait_edges(REF_N);
        check("R10", refresh_due, 1);
        dstep(5, 0, 0, 1'b1, "R7");
        @(negedge clk); #1;
        check("R7", refresh_due, 0);
        idle(20);

        // Activate / column / precharge boundaries
        dstep(0, 0, 0, 1'b1, "R2");
        dstep(0, 1, 0, 1'b0, "R2");
        dstep(2, 0, 0, 1'b0, "R4");
        dstep(0, 1, 0, 1'b1, "R2");
        dstep(1, 0, 0, 1'b0, "R3");
        dstep(2, 0, 0, 1'b1, "R4");
        dstep(1, 0, 0, 1'b0, "R3");
        idle(1);
        dstep(1, 0, 0, 1'b1, "R3");
        dstep(3, 0, 0, 1'b0, "R5");
        dstep(3, 0, 0, 1'b1, "R5");
        dstep(6, 0, 0, 1'b0, "R8");
        dstep(0, 0, 0, 1'b0, "R2");
        dstep(3, 1, 0, 1'b1, "R5");
        dstep(3, 2, 0, 1'b1, "R5");
        dstep(0, 0, 0, 1'b1, "R2");
        dstep(0, 1, 0, 1'b0, "R2");
        idle(3);
        dstep(1, 0, 1'b1, 1'b1, "R6");
        dstep(1, 0, 0, 1'b0, "R6");
        check("R6", bank_open[0], 0);

        // Refresh and mode write blocking
        idle(10);
        dstep(5, 0, 0, 1'b1, "R7");
        idle(15);
        dstep(0, 0, 0, 1'b0, "R7");
        dstep(0, 0, 0, 1'b1, "R7");
        idle(9);
        dstep(3, 0, 0, 1'b1, "R5");
        idle(4);
        dstep(6, 0, 0, 1'b1, "R8");
        dstep(0, 0, 0, 1'b0, "R8");
        dstep(0, 0, 0, 1'b1, "R8");
        dstep(7, 2, 0, 1'b0, "R9");
        check("R9", bank_open[2], 0);

        // Row held open too long
        idle(3);
        dstep(0, 3, 0, 1'b1, "R11");
        r = last_c;
        wait_edges(r + AGE_N + 1);
        check("R11", row_overdue[3], 0);
        wait_edges(r + AGE_N + 2);
        check("R11", row_overdue[3], 1);
        step(1'b1, 4, 0, 1'b0);
        idle(6);

        // Weighted random traffic
        for (int k = 0; k < 3000; k++) begin
            r  = $urandom % 16;
            b  = $urandom % 4;
            ap = (($urandom % 4) == 0);
            if (r < 4) op = -1;
            else if (r < 7) op = 0;
            else if (r < 9) op = 1;
            else if (r < 11) op = 2;
            else if (r < 13) op = 3;
            else if (r == 13) op = 4;
            else if (r == 14) op = 5;
            else op = (($urandom % 2) == 0) ? 6 : 7;
            if (op < 0) step(1'b0, 0, b, 1'b0);
            else        step(1'b1, op, b, ap);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule